// File: doc/BRIEF.md
# Associative Lock and Barrier Engine

This block is a shared synchronization coprocessor for a multiprocessor system whose cores have no atomic instructions. Each core owns one point-to-point request port. A core posts a command (take a lock, release a lock, arrive at a barrier, or poll a barrier) tagged with a 32-bit key, usually a shared address. The block answers on the same port with a status code. Cores that are refused or told to wait retry by polling the block, so busy-waiting never touches shared memory.

Locks and barriers share one content-addressed key table. Each entry holds the key, the port that created it, a kind flag (lock or barrier) and a countdown of the barrier arrivals still missing. Requests are queued in order of arrival, with the lower port index first when several arrive in the same cycle. The engine carries out one queued command at a time. The lookup and the table update of a command finish before the next command starts, so every command is atomic.

Top module: `lbe_engine`

## Requirements
- R1: A port's request (req_valid high for one cycle) is accepted only while that port has no outstanding request. A request from a port that is still waiting is ignored. Every accepted request produces exactly one resp_valid pulse on its own port.
- R2: Accepted requests are served in the order they arrived. Requests accepted in the same cycle are served lowest port index first.
- R3: Commands execute one at a time, and at most one port receives a response in any cycle.
- R4: Lock (command 0). If the key is absent, it is placed in the lowest free entry with the requester as owner, and the status is GRANTED (0). If the key is present, whether as a lock or a barrier, the status is BUSY (1) and nothing changes.
- R5: Unlock (command 1). If the key is a lock owned by the requesting port, the entry is freed and the status is RELEASED (2). In every other case the status is ERROR (5) and nothing changes.
- R6: Barrier arrive (command 2) with an absent key and a participant count N of 2 or more allocates an entry whose countdown is N-1 and returns WAIT (3). With N of 0 or 1 it returns RELEASED (2) and allocates nothing.
- R7: Barrier arrive with a key that is present as a barrier decrements the countdown. The arrival that brings the countdown to zero frees the entry and gets RELEASED (2). Earlier arrivals get WAIT (3). An arrival on a key held as a lock returns ERROR (5) and changes nothing.
- R8: Barrier poll (command 3) returns WAIT (3) while the key is present and RELEASED (2) once it is gone. It never modifies the table.
- R9: A lock or a new barrier that needs an entry when every entry is in use returns FULL (4) and changes no state. A freed entry can be allocated again.
- R10: Synchronous reset empties the table, the queue and all outstanding requests, and holds every resp_valid low.
- R11: A key is never held by more than one entry, and a live barrier entry always has a nonzero countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | One-cycle request strobe per port |
| req_cmd | input | 2*NPORT | Command per port: 0 lock, 1 unlock, 2 barrier arrive, 3 barrier poll |
| req_id | input | IDW*NPORT | Key per port |
| req_count | input | CW*NPORT | Barrier participant count per port, CW = clog2(NPORT+1) |
| resp_valid | output | NPORT | One-cycle response strobe per port |
| resp_status | output | 3*NPORT | Status per port, held until the port's next response |

## Verification
The bench builds the engine with four ports and four table entries. With only four entries, the full condition can be reached after a handful of grants, and the bench can show that a freed slot is allocated again. Four ports allow three ports to arrive at one barrier in a single cycle, which tests same-cycle priority against the countdown release. They also allow a request order across two cycles that contradicts port priority. The smaller count width also puts the N of 0 or 1 barrier shortcut in the stimulus.

// File: rtl/lbe_pkg.sv
package lbe_pkg;

  typedef enum logic [1:0] {
    CMD_LOCK    = 2'd0,
    CMD_UNLOCK  = 2'd1,
    CMD_ARRIVE  = 2'd2,
    CMD_POLL    = 2'd3
  } lbe_cmd_e;

  typedef enum logic [2:0] {
    ST_GRANT = 3'd0,
    ST_BUSY  = 3'd1,
    ST_REL   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_FULL  = 3'd4,
    ST_ERR   = 3'd5
  } lbe_status_e;

  localparam int STW = 3;

endpackage

// File: rtl/lbe_arbiter.sv
// Arrival-order queue of port indices; same-cycle arrivals enter lowest index first.
module lbe_arbiter #(
  parameter int NPORT = 8,
  parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] push,
  input  logic             pop,
  output logic [PW-1:0]    head,
  output logic             not_empty
);

  localparam int QW = $clog2(NPORT + 1);

  logic [PW-1:0] slot_q [NPORT];
  logic [PW-1:0] rd_q;
  logic [QW-1:0] fill_q;
  logic [PW-1:0] pos [NPORT];
  logic [QW-1:0] npush;

  always_comb begin
    int rank;
    rank = 0;
    for (int i = 0; i < NPORT; i++) begin
      pos[i] = PW'((int'(rd_q) + int'(fill_q) + rank) % NPORT);
      if (push[i]) rank = rank + 1;
    end
    npush = QW'(rank);
  end

  assign head      = slot_q[rd_q];
  assign not_empty = (fill_q != '0);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORT; i++) begin
      if (push[i]) slot_q[pos[i]] <= PW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (pop) rd_q <= PW'((int'(rd_q) + 1) % NPORT);
      fill_q <= fill_q + npush - QW'(pop);
    end
  end

  // R2: the queue never holds more than one entry per port
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(fill_q) <= NPORT);

  // R2: nothing is taken from an empty queue
  a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> not_empty);

endmodule

// File: rtl/lbe_table.sv
// Content-addressed key table with owner, kind and countdown per entry.
module lbe_table #(
  parameter int NENT = 16,
  parameter int IDW  = 32,
  parameter int PW   = 3,
  parameter int CW   = 4,
  parameter int EW   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDW-1:0]  look_id,
  output logic            hit,
  output logic [EW-1:0]   hit_idx,
  output logic            hit_bar,
  output logic [PW-1:0]   hit_owner,
  output logic [CW-1:0]   hit_cnt,
  output logic            free_ok,
  output logic [NENT-1:0] occ,
  input  logic            alloc,
  input  logic            alloc_bar,
  input  logic [PW-1:0]   alloc_owner,
  input  logic [CW-1:0]   alloc_cnt,
  input  logic            clr,
  input  logic            dec
);

  logic [NENT-1:0] valid_q;
  logic [IDW-1:0]  id_q    [NENT];
  logic            bar_q   [NENT];
  logic [PW-1:0]   own_q   [NENT];
  logic [CW-1:0]   cnt_q   [NENT];
  logic [NENT-1:0] match;
  logic [EW-1:0]   free_idx;

  for (genvar e = 0; e < NENT; e++) begin : g_cmp
    assign match[e] = valid_q[e] && (id_q[e] == look_id);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (match[e])    hit_idx  = EW'(e);
      if (!valid_q[e]) free_idx = EW'(e);
    end
  end

  assign hit       = |match;
  assign free_ok   = ~&valid_q;
  assign hit_bar   = bar_q[hit_idx];
  assign hit_owner = own_q[hit_idx];
  assign hit_cnt   = cnt_q[hit_idx];
  assign occ       = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (alloc) valid_q[free_idx] <= 1'b1;
      if (clr)   valid_q[hit_idx]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      id_q[free_idx]  <= look_id;
      bar_q[free_idx] <= alloc_bar;
      own_q[free_idx] <= alloc_owner;
      cnt_q[free_idx] <= alloc_cnt;
    end else if (dec) begin
      cnt_q[hit_idx] <= cnt_q[hit_idx] - CW'(1);
    end
  end

  logic dup_key, zero_bar;
  always_comb begin
    dup_key  = 1'b0;
    zero_bar = 1'b0;
    for (int a = 0; a < NENT; a++) begin
      if (valid_q[a] && bar_q[a] && cnt_q[a] == '0) zero_bar = 1'b1;
      for (int b = a + 1; b < NENT; b++) begin
        if (valid_q[a] && valid_q[b] && id_q[a] == id_q[b]) dup_key = 1'b1;
      end
    end
  end

  // R11: a key occupies at most one entry
  a_r11_unique_key: assert property (@(posedge clk) disable iff (rst) !dup_key);

  // R11: a live barrier always waits for at least one more arrival
  a_r11_bar_nonzero: assert property (@(posedge clk) disable iff (rst) !zero_bar);

  // R4: allocation only targets a free slot, and never for a present key
  a_r4_alloc_on_miss: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (free_ok && !hit));

endmodule

// File: rtl/lbe_engine.sv
// Top: per-port request capture, arrival queue, atomic command execution.
module lbe_engine
  import lbe_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int NENT  = 16,
  parameter int IDW   = 32,
  parameter int CW    = $clog2(NPORT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORT-1:0]     req_valid,
  input  logic [2*NPORT-1:0]   req_cmd,
  input  logic [IDW*NPORT-1:0] req_id,
  input  logic [CW*NPORT-1:0]  req_count,
  output logic [NPORT-1:0]     resp_valid,
  output logic [STW*NPORT-1:0] resp_status
);

  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int EW = (NENT > 1) ? $clog2(NENT) : 1;

  logic [NPORT-1:0]     pend_q;
  logic [NPORT-1:0]     accept;
  logic [1:0]           p_cmd [NPORT];
  logic [IDW-1:0]       p_id  [NPORT];
  logic [CW-1:0]        p_cnt [NPORT];
  logic                 busy_q;
  logic [PW-1:0]        cur_q;
  logic                 pop, not_empty;
  logic [PW-1:0]        head;
  logic [NPORT-1:0]     rv_q;
  logic [STW*NPORT-1:0] rs_q;

  assign accept = req_valid & ~pend_q;
  assign pop    = !busy_q && not_empty;

  lbe_arbiter #(.NPORT(NPORT), .PW(PW)) arb_i (
    .clk(clk), .rst(rst), .push(accept), .pop(pop),
    .head(head), .not_empty(not_empty)
  );

  // Payload registers per port, held while the request is outstanding.
  for (genvar p = 0; p < NPORT; p++) begin : g_cap
    always_ff @(posedge clk) begin
      if (accept[p]) begin
        p_cmd[p] <= req_cmd[2*p +: 2];
        p_id[p]  <= req_id[IDW*p +: IDW];
        p_cnt[p] <= req_count[CW*p +: CW];
      end
    end
  end

  lbe_cmd_e      cur_cmd;
  logic [IDW-1:0] cur_id;
  logic [CW-1:0]  cur_cnt;
  assign cur_cmd = lbe_cmd_e'(p_cmd[cur_q]);
  assign cur_id  = p_id[cur_q];
  assign cur_cnt = p_cnt[cur_q];

  logic            hit, hit_bar, free_ok;
  logic [EW-1:0]   hit_idx;
  logic [PW-1:0]   hit_owner;
  logic [CW-1:0]   hit_cnt;
  logic [NENT-1:0] occ;
  logic            do_alloc, do_bar, do_clr, do_dec;
  lbe_status_e     st;

  always_comb begin
    do_alloc = 1'b0;
    do_bar   = 1'b0;
    do_clr   = 1'b0;
    do_dec   = 1'b0;
    st       = ST_ERR;
    unique case (cur_cmd)
      CMD_LOCK: begin
        if (hit) st = ST_BUSY;
        else if (free_ok) begin do_alloc = 1'b1; st = ST_GRANT; end
        else st = ST_FULL;
      end
      CMD_UNLOCK: begin
        if (hit && !hit_bar && hit_owner == cur_q) begin
          do_clr = 1'b1;
          st     = ST_REL;
        end
      end
      CMD_ARRIVE: begin
        if (hit) begin
          if (hit_bar) begin
            if (hit_cnt == CW'(1)) begin do_clr = 1'b1; st = ST_REL; end
            else begin do_dec = 1'b1; st = ST_WAIT; end
          end
        end else if (cur_cnt <= CW'(1)) begin
          st = ST_REL;
        end else if (free_ok) begin
          do_alloc = 1'b1;
          do_bar   = 1'b1;
          st       = ST_WAIT;
        end else begin
          st = ST_FULL;
        end
      end
      CMD_POLL: st = hit ? ST_WAIT : ST_REL;
      default:  st = ST_ERR;
    endcase
  end

  lbe_table #(.NENT(NENT), .IDW(IDW), .PW(PW), .CW(CW), .EW(EW)) tbl_i (
    .clk(clk), .rst(rst), .look_id(cur_id),
    .hit(hit), .hit_idx(hit_idx), .hit_bar(hit_bar), .hit_owner(hit_owner),
    .hit_cnt(hit_cnt), .free_ok(free_ok), .occ(occ),
    .alloc(busy_q && do_alloc), .alloc_bar(do_bar), .alloc_owner(cur_q),
    .alloc_cnt(cur_cnt - CW'(1)),
    .clr(busy_q && do_clr), .dec(busy_q && do_dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      busy_q <= 1'b0;
      cur_q  <= '0;
      rv_q   <= '0;
      rs_q   <= '0;
    end else begin
      rv_q <= '0;
      for (int p = 0; p < NPORT; p++) begin
        if (accept[p]) pend_q[p] <= 1'b1;
      end
      if (pop) begin
        busy_q <= 1'b1;
        cur_q  <= head;
      end
      if (busy_q) begin
        busy_q                <= 1'b0;
        pend_q[cur_q]         <= 1'b0;
        rv_q[cur_q]           <= 1'b1;
        rs_q[STW*cur_q +: STW] <= st;
      end
    end
  end

  assign resp_valid  = rv_q;
  assign resp_status = rs_q;

  // R3: responses are serialized
  a_r3_one_resp: assert property (@(posedge clk) disable iff (rst)
    $onehot0(resp_valid));

  // R1: the command being executed belongs to a waiting port
  a_r1_exec_pending: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> pend_q[cur_q]);

  // R9: a full refusal leaves the table occupancy untouched
  a_r9_full_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_q && st == ST_FULL) |=> $stable(occ));

  // R4: a grant adds exactly one occupied entry
  a_r4_grant_adds: assert property (@(posedge clk) disable iff (rst)
    (busy_q && st == ST_GRANT) |=> ($countones(occ) == $countones($past(occ)) + 1));

  // R8: a poll never changes occupancy
  a_r8_poll_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cur_cmd == CMD_POLL) |=> $stable(occ));

endmodule

// File: tb/lbe_engine_tb.sv
module lbe_engine_tb_top;
  import lbe_pkg::*;

  localparam int NPORT = 4;
  localparam int NENT  = 4;
  localparam int IDW   = 32;
  localparam int CW    = $clog2(NPORT + 1);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NPORT-1:0]     req_valid = '0;
  logic [2*NPORT-1:0]   req_cmd = '0;
  logic [IDW*NPORT-1:0] req_id = '0;
  logic [CW*NPORT-1:0]  req_count = '0;
  logic [NPORT-1:0]     resp_valid;
  logic [3*NPORT-1:0]   resp_status;

  always #4 clk = ~clk;  // 125 MHz

  lbe_engine #(.NPORT(NPORT), .NENT(NENT), .IDW(IDW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_id(req_id), .req_count(req_count),
    .resp_valid(resp_valid), .resp_status(resp_status)
  );

  int nchk = 0;
  int nfail = 0;
  int rcnt [NPORT];
  logic [2:0] rstat [NPORT];

  initial for (int p = 0; p < NPORT; p++) begin rcnt[p] = 0; rstat[p] = '0; end

  always @(negedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (resp_valid[p]) begin
        rcnt[p]  <= rcnt[p] + 1;
        rstat[p] <= resp_status[3*p +: 3];
      end
    end
  end

  typedef struct packed {
    logic [7:0]  rq;
    logic [7:0]  port;
    logic [1:0]  cmd;
    logic [31:0] id;
    logic [3:0]  cnt;
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{8'd4,  8'd0, 2'd0, 32'h0000_00A0, 4'd0, 3'd0}, // R4 lock miss -> grant
    '{8'd4,  8'd1, 2'd0, 32'h0000_00A0, 4'd0, 3'd1}, // R4 lock hit -> busy
    '{8'd5,  8'd1, 2'd1, 32'h0000_00A0, 4'd0, 3'd5}, // R5 unlock by non-owner
    '{8'd8,  8'd1, 2'd3, 32'h0000_00A0, 4'd0, 3'd3}, // R8 poll present
    '{8'd5,  8'd0, 2'd1, 32'h0000_00A0, 4'd0, 3'd2}, // R5 owner unlock
    '{8'd4,  8'd1, 2'd0, 32'h0000_00A0, 4'd0, 3'd0}, // R4 retry now granted
    '{8'd5,  8'd1, 2'd1, 32'h0000_00A0, 4'd0, 3'd2}, // R5
    '{8'd5,  8'd2, 2'd1, 32'h0000_00B0, 4'd0, 3'd5}, // R5 unlock of absent key
    '{8'd6,  8'd0, 2'd2, 32'h0000_00C0, 4'd3, 3'd3}, // R6 barrier create
    '{8'd7,  8'd1, 2'd2, 32'h0000_00C0, 4'd3, 3'd3}, // R7 second arrival waits
    '{8'd8,  8'd0, 2'd3, 32'h0000_00C0, 4'd0, 3'd3}, // R8 still waiting
    '{8'd4,  8'd1, 2'd0, 32'h0000_00C0, 4'd0, 3'd1}, // R4 lock on barrier key
    '{8'd7,  8'd2, 2'd2, 32'h0000_00C0, 4'd3, 3'd2}, // R7 last arrival releases
    '{8'd8,  8'd0, 2'd3, 32'h0000_00C0, 4'd0, 3'd2}, // R8 released after removal
    '{8'd6,  8'd3, 2'd2, 32'h0000_00D0, 4'd1, 3'd2}, // R6 single-party barrier
    '{8'd6,  8'd3, 2'd3, 32'h0000_00D0, 4'd0, 3'd2}, // R6 nothing allocated
    '{8'd4,  8'd0, 2'd0, 32'h0000_00E0, 4'd0, 3'd0}, // R4
    '{8'd7,  8'd0, 2'd2, 32'h0000_00E0, 4'd2, 3'd5}, // R7 arrival on lock key
    '{8'd5,  8'd0, 2'd1, 32'h0000_00E0, 4'd0, 3'd2}  // R5
  };

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic [1:0] c, input logic [31:0] id, input int n);
    req_valid[p]             = 1'b1;
    req_cmd[2*p +: 2]        = c;
    req_id[IDW*p +: IDW]     = id;
    req_count[CW*p +: CW]    = CW'(n);
  endtask

  task automatic wait_count(input int p, input int target, input string tag);
    int k;
    k = 0;
    while (rcnt[p] < target && k < 40) begin
      @(negedge clk);
      k++;
    end
    if (rcnt[p] < target) begin
      nchk++;
      nfail++;
      $display("FAIL %s actual=timeout expected=response", tag);
    end
  endtask

  task automatic run_one(input int p, input logic [1:0] c, input logic [31:0] id,
                         input int n, input int exp, input string tag);
    int base;
    base = rcnt[p];
    drive(p, c, id, n);
    @(negedge clk);
    req_valid = '0;
    wait_count(p, base + 1, tag);
    check(tag, int'(rstat[p]), exp);
  endtask

  initial begin
    int b1, b3, b0, b2;
    repeat (3) @(negedge clk);
    check("R10 resp_valid in reset", int'(resp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 resp_valid after reset", int'(resp_valid), 0);

    for (int i = 0; i < NV; i++)
      run_one(int'(VEC[i].port), VEC[i].cmd, VEC[i].id, int'(VEC[i].cnt),
              int'(VEC[i].exp), $sformatf("R%0d vector %0d", VEC[i].rq, i));

    // R9: fill all four entries, then refuse allocations
    for (int p = 0; p < NPORT; p++) run_one(p, 2'd0, 32'h100 + p, 0, 0, "R9 fill");
    run_one(0, 2'd0, 32'h1F0, 0, 4, "R9 lock when full");
    run_one(0, 2'd2, 32'h1F1, 2, 4, "R9 barrier when full");
    run_one(1, 2'd3, 32'h1F0, 0, 2, "R9 refused key absent");
    run_one(2, 2'd0, 32'h102, 0, 1, "R9 held key still busy");
    run_one(0, 2'd1, 32'h100, 0, 2, "R9 free one");
    run_one(1, 2'd0, 32'h1F0, 0, 0, "R9 freed slot reused");
    run_one(1, 2'd1, 32'h1F0, 0, 2, "R9 cleanup");
    for (int p = 1; p < NPORT; p++) run_one(p, 2'd1, 32'h100 + p, 0, 2, "R9 cleanup");

    // R2 same cycle: port 1 beats port 3; R1 repeat from port 3 ignored
    b1 = rcnt[1]; b3 = rcnt[3];
    drive(3, 2'd0, 32'hF0, 0);
    drive(1, 2'd0, 32'hF0, 0);
    @(negedge clk);
    req_valid = '0;
    drive(3, 2'd0, 32'hF9, 0);
    @(negedge clk);
    req_valid = '0;
    repeat (20) @(negedge clk);
    check("R2 port1 first", int'(rstat[1]), 0);
    check("R2 port3 second", int'(rstat[3]), 1);
    check("R1 single response port3", rcnt[3] - b3, 1);
    check("R1 single response port1", rcnt[1] - b1, 1);
    run_one(0, 2'd3, 32'hF9, 0, 2, "R1 ignored request left no entry");
    run_one(1, 2'd1, 32'hF0, 0, 2, "R5 cleanup");

    // R2 arrival order across cycles overrides port index
    b0 = rcnt[0]; b2 = rcnt[2];
    drive(2, 2'd0, 32'hF1, 0);
    @(negedge clk);
    req_valid = '0;
    drive(0, 2'd0, 32'hF1, 0);
    @(negedge clk);
    req_valid = '0;
    wait_count(0, b0 + 1, "R2 port0");
    wait_count(2, b2 + 1, "R2 port2");
    check("R2 earlier port2 granted", int'(rstat[2]), 0);
    check("R2 later port0 busy", int'(rstat[0]), 1);
    run_one(2, 2'd1, 32'hF1, 0, 2, "R5 cleanup");

    // R7 three arrivals in one cycle, count 3
    b0 = rcnt[0]; b1 = rcnt[1]; b2 = rcnt[2];
    drive(0, 2'd2, 32'h4400, 3);
    drive(1, 2'd2, 32'h4400, 3);
    drive(2, 2'd2, 32'h4400, 3);
    @(negedge clk);
    req_valid = '0;
    wait_count(2, b2 + 1, "R7 burst");
    check("R7 burst p0 waits", int'(rstat[0]), 3);
    check("R7 burst p1 waits", int'(rstat[1]), 3);
    check("R7 burst p2 releases", int'(rstat[2]), 2);
    run_one(3, 2'd3, 32'h4400, 0, 2, "R8 burst barrier gone");

    // R10: reset drops a held lock
    run_one(0, 2'd0, 32'h6000, 0, 0, "R10 setup");
    rst = 1'b1;
    @(negedge clk);
    check("R10 no response in reset", int'(resp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    run_one(1, 2'd0, 32'h6000, 0, 0, "R10 table emptied");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
    $finish;
  end

endmodule